// File: doc/BRIEF.md
# SDRAM Read Burst Sequencer

This block is the read half of a single-data-rate SDRAM controller. A request carries a bank, a start column, an auto-precharge flag and an identifier. The block puts a READ command on the command bus one cycle later. It then follows the device's own column progression and captures each returning data word from the DQ bus at the programmed CAS latency. Every captured word leaves on a streaming output with a valid flag, a last flag, the identifier of the request that produced it and the column it came from.

Bank activation, precharge scheduling, refresh and write traffic are handled elsewhere. The block only issues READs and tracks the data those READs return. A tag pipeline as deep as the CAS latency runs alongside the command timeline. A new READ can therefore land so that its first word comes on the cycle after the last wanted word of the previous burst. This lets the stream stay gap-free whether the new READ follows a finished fixed burst or cuts a running one short. Full-page bursts run until a new READ or the stop input ends them, and they wrap around the page.

Top module: `sdram_rd_seq`

## Requirements
- R1: A request sampled at clock edge t shows on the command bus during the cycle after edge t, with `cmd_read` high and `cmd_bank`, `cmd_col` and `cmd_ap` equal to the request's bank, column and auto-precharge flag. `cmd_read` is low in every cycle with no request at the preceding edge.
- R2: Word i of a burst whose request was sampled at edge t is the DQ value present at edge t+1+CL+i. It appears on the output, with `out_valid` high, in the cycle after that edge. The words of one burst come out on consecutive cycles with no gap.
- R3: `cfg_cl3` = 1 selects a CAS latency of 3 and `cfg_cl3` = 0 selects a CAS latency of 2.
- R4: With `cfg_full` = 0, `cfg_bl` codes 0, 1, 2 and 3 give fixed bursts of 1, 2, 4 and 8 words. The final word of an uninterrupted fixed burst carries `out_last` = 1, and no other word of it does.
- R5: A fixed burst of length L starting at column c visits the columns of the L-aligned block that holds c in ascending order, starting at c and wrapping within that block. `out_col` reports each word's column.
- R6: With `cfg_full` = 1 the burst has no fixed end. The column advances by one per word modulo 2^COL_W, so after the last column of the page it returns to column 0.
- R7: A request sampled at edge t while a burst is running ends that burst. The old word valid at edge t+CL is its last kept word and carries `out_last` = 1. Later old words are dropped, and the new burst's first word follows on the next cycle.
- R8: `stop` sampled high at edge t (with no request) ends the running burst, and the word valid at edge t+CL carries `out_last` = 1. With no burst running, `stop` has no effect on any output.
- R9: DQ is ignored when no burst word is due. `out_valid` stays low in those cycles, also in the idle gaps between separated fixed bursts.
- R10: `cfg_cl3`, `cfg_bl` and `cfg_full` take effect only while the block is idle (no burst running and no word in flight). Changes made during a burst do not alter that burst's length, columns or timing.
- R11: While `rst` is high at a clock edge, `cmd_read`, `out_valid` and `out_last` are low after that edge, even if a request is present.
- R12: Every word's `out_id` equals the identifier of the request that produced it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_cl3 | input | 1 | CAS latency select: 1 = 3 cycles, 0 = 2 cycles |
| cfg_bl | input | 2 | Fixed burst length code: 0/1/2/3 = 1/2/4/8 words |
| cfg_full | input | 1 | 1 = full-page burst |
| req_valid | input | 1 | Read request strobe, one per cycle at most |
| req_bank | input | BANK_W | Bank of the request |
| req_col | input | COL_W | Start column of the request |
| req_ap | input | 1 | Auto precharge after the burst |
| req_id | input | ID_W | Request identifier |
| stop | input | 1 | Ends the running burst |
| dq | input | DQ_W | Data bus from the device |
| cmd_read | output | 1 | READ command strobe |
| cmd_bank | output | BANK_W | Bank of the READ |
| cmd_col | output | COL_W | Column of the READ |
| cmd_ap | output | 1 | Auto-precharge flag of the READ |
| out_valid | output | 1 | Captured word valid |
| out_last | output | 1 | Final word of its burst |
| out_id | output | ID_W | Identifier of the word's request |
| out_col | output | COL_W | Column of the word |
| out_data | output | DQ_W | Captured data |

## Verification
The hardest case to reach is the edge at which one burst ends and the next begins. A request or stop must land exactly CL-1 cycles before the last wanted word, and several words of the old burst are still in flight in the latency pipeline. The stimulus table reaches it by spacing requests one, two or three cycles apart, shorter than the burst, and by stopping a fixed burst and a full-page burst part way through. A full-page run started a few columns below the top of the page covers the wrap. The bench drives DQ with the number of the clock edge, so each captured value shows the exact edge it came from and proves both the latency and the absence of gaps.

// File: rtl/sdram_rd_pkg.sv
package sdram_rd_pkg;

    // Deepest CAS latency supported; tag pipeline depth.
    localparam int MAX_CL = 3;

    typedef enum logic [1:0] {
        BL_1 = 2'd0,
        BL_2 = 2'd1,
        BL_4 = 2'd2,
        BL_8 = 2'd3
    } bl_code_e;

    // Number of words in a fixed burst.
    function automatic logic [3:0] bl_words(input bl_code_e code);
        return 4'd1 << code;
    endfunction

    // Low-column mask of the burst-aligned block.
    function automatic logic [2:0] bl_mask(input bl_code_e code);
        return 3'(bl_words(code) - 4'd1);
    endfunction

    // Sequential step inside the aligned block.
    function automatic logic [2:0] wrap_low(input logic [2:0] low, input logic [2:0] mask);
        return (low & ~mask) | ((low + 3'd1) & mask);
    endfunction

endpackage

// File: rtl/sdram_rd_cmd.sv
module sdram_rd_cmd #(
    parameter int BANK_W = 2,
    parameter int COL_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [COL_W-1:0]  req_col,
    input  logic              req_ap,
    output logic              cmd_read,
    output logic [BANK_W-1:0] cmd_bank,
    output logic [COL_W-1:0]  cmd_col,
    output logic              cmd_ap
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_read <= 1'b0;
            cmd_bank <= '0;
            cmd_col  <= '0;
            cmd_ap   <= 1'b0;
        end else begin
            cmd_read <= req_valid;
            if (req_valid) begin
                cmd_bank <= req_bank;
                cmd_col  <= req_col;
                cmd_ap   <= req_ap;
            end
        end
    end

endmodule

// File: rtl/sdram_rd_burst.sv
module sdram_rd_burst
    import sdram_rd_pkg::*;
#(
    parameter int COL_W = 8,
    parameter int ID_W  = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [COL_W-1:0] ld_col,
    input  logic [ID_W-1:0]  ld_id,
    input  logic             stop,
    input  bl_code_e         bl,
    input  logic             full,
    output logic             tag_valid,
    output logic             tag_last,
    output logic [ID_W-1:0]  tag_id,
    output logic [COL_W-1:0] tag_col
);

    logic             act;
    logic             full_r;
    logic [2:0]       mask_r;
    logic [2:0]       left;
    logic [COL_W-1:0] col;
    logic [ID_W-1:0]  id;
    logic             fixed_end;

    assign fixed_end = !full_r && (left == 3'd0);
    assign tag_valid = act;
    assign tag_last  = act && (fixed_end || load || stop);
    assign tag_id    = id;
    assign tag_col   = col;

    always_ff @(posedge clk) begin
        if (rst) begin
            act    <= 1'b0;
            full_r <= 1'b0;
            mask_r <= '0;
            left   <= '0;
            col    <= '0;
            id     <= '0;
        end else if (load) begin
            act    <= 1'b1;
            full_r <= full;
            mask_r <= bl_mask(bl);
            left   <= bl_mask(bl);
            col    <= ld_col;
            id     <= ld_id;
        end else if (stop) begin
            act <= 1'b0;
        end else if (act) begin
            if (fixed_end) begin
                act <= 1'b0;
            end else begin
                if (full_r) begin
                    col <= col + 1'b1;
                end else begin
                    col  <= {col[COL_W-1:3], wrap_low(col[2:0], mask_r)};
                    left <= left - 3'd1;
                end
            end
        end
    end

    // Checker counter: index of the current word within its burst.
    logic [3:0] chk_idx;
    always_ff @(posedge clk) begin
        if (rst || load) chk_idx <= '0;
        else if (act && chk_idx != 4'hF) chk_idx <= chk_idx + 4'd1;
    end

    // R4: a fixed burst never produces a ninth word
    a_r4_fixed_len: assert property (@(posedge clk) disable iff (rst)
        (act && !full_r) |-> (chk_idx < 4'd8));

    // R8: stop without a request ends the burst
    a_r8_stop_ends: assert property (@(posedge clk) disable iff (rst)
        (stop && !load) |=> !tag_valid);

endmodule

// File: rtl/sdram_rd_capture.sv
module sdram_rd_capture
    import sdram_rd_pkg::*;
#(
    parameter int DQ_W  = 16,
    parameter int COL_W = 8,
    parameter int ID_W  = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cl3,
    input  logic             tag_valid,
    input  logic             tag_last,
    input  logic [ID_W-1:0]  tag_id,
    input  logic [COL_W-1:0] tag_col,
    input  logic [DQ_W-1:0]  dq,
    output logic             pipe_busy,
    output logic             out_valid,
    output logic             out_last,
    output logic [ID_W-1:0]  out_id,
    output logic [COL_W-1:0] out_col,
    output logic [DQ_W-1:0]  out_data
);

    typedef struct packed {
        logic             valid;
        logic             last;
        logic [ID_W-1:0]  id;
        logic [COL_W-1:0] col;
    } tag_t;

    tag_t pipe [MAX_CL];
    tag_t tap;

    always_ff @(posedge clk) begin
        if (rst) pipe[0] <= '0;
        else     pipe[0] <= '{valid: tag_valid, last: tag_last, id: tag_id, col: tag_col};
    end

    for (genvar g = 1; g < MAX_CL; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) pipe[g] <= '0;
            else     pipe[g] <= pipe[g-1];
        end
    end

    assign tap = cl3 ? pipe[MAX_CL-1] : pipe[MAX_CL-2];

    always_comb begin
        pipe_busy = 1'b0;
        for (int i = 0; i < MAX_CL; i++) pipe_busy = pipe_busy | pipe[i].valid;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_last  <= 1'b0;
            out_id    <= '0;
            out_col   <= '0;
            out_data  <= '0;
        end else begin
            out_valid <= tap.valid;
            out_last  <= tap.valid && tap.last;
            out_id    <= tap.valid ? tap.id  : '0;
            out_col   <= tap.valid ? tap.col : '0;
            out_data  <= tap.valid ? dq      : '0;
        end
    end

    // R2: within a burst the words are back to back
    a_r2_no_gap: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_last) |=> out_valid);

endmodule

// File: rtl/sdram_rd_seq.sv
module sdram_rd_seq
    import sdram_rd_pkg::*;
#(
    parameter int BANK_W = 2,
    parameter int COL_W  = 8,
    parameter int ID_W   = 4,
    parameter int DQ_W   = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_cl3,
    input  logic [1:0]        cfg_bl,
    input  logic              cfg_full,
    input  logic              req_valid,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [COL_W-1:0]  req_col,
    input  logic              req_ap,
    input  logic [ID_W-1:0]   req_id,
    input  logic              stop,
    input  logic [DQ_W-1:0]   dq,
    output logic              cmd_read,
    output logic [BANK_W-1:0] cmd_bank,
    output logic [COL_W-1:0]  cmd_col,
    output logic              cmd_ap,
    output logic              out_valid,
    output logic              out_last,
    output logic [ID_W-1:0]   out_id,
    output logic [COL_W-1:0]  out_col,
    output logic [DQ_W-1:0]   out_data
);

    localparam int NUM_COLS = 2 ** COL_W;

    logic             tag_valid, tag_last, pipe_busy, busy;
    logic [ID_W-1:0]  tag_id;
    logic [COL_W-1:0] tag_col;

    // Configuration held while anything is in flight.
    logic     cl3_q, full_q, cl3_e, full_e;
    bl_code_e bl_q, bl_e;

    assign busy   = tag_valid || pipe_busy;
    assign cl3_e  = busy ? cl3_q  : cfg_cl3;
    assign full_e = busy ? full_q : cfg_full;
    assign bl_e   = busy ? bl_q   : bl_code_e'(cfg_bl);

    always_ff @(posedge clk) begin
        if (rst) begin
            cl3_q  <= 1'b0;
            full_q <= 1'b0;
            bl_q   <= BL_1;
        end else if (!busy) begin
            cl3_q  <= cfg_cl3;
            full_q <= cfg_full;
            bl_q   <= bl_code_e'(cfg_bl);
        end
    end

    sdram_rd_cmd #(.BANK_W(BANK_W), .COL_W(COL_W)) u_cmd (
        .clk      (clk),
        .rst      (rst),
        .req_valid(req_valid),
        .req_bank (req_bank),
        .req_col  (req_col),
        .req_ap   (req_ap),
        .cmd_read (cmd_read),
        .cmd_bank (cmd_bank),
        .cmd_col  (cmd_col),
        .cmd_ap   (cmd_ap)
    );

    sdram_rd_burst #(.COL_W(COL_W), .ID_W(ID_W)) u_burst (
        .clk      (clk),
        .rst      (rst),
        .load     (req_valid),
        .ld_col   (req_col),
        .ld_id    (req_id),
        .stop     (stop),
        .bl       (bl_e),
        .full     (full_e),
        .tag_valid(tag_valid),
        .tag_last (tag_last),
        .tag_id   (tag_id),
        .tag_col  (tag_col)
    );

    sdram_rd_capture #(.DQ_W(DQ_W), .COL_W(COL_W), .ID_W(ID_W)) u_cap (
        .clk      (clk),
        .rst      (rst),
        .cl3      (cl3_q),
        .tag_valid(tag_valid),
        .tag_last (tag_last),
        .tag_id   (tag_id),
        .tag_col  (tag_col),
        .dq       (dq),
        .pipe_busy(pipe_busy),
        .out_valid(out_valid),
        .out_last (out_last),
        .out_id   (out_id),
        .out_col  (out_col),
        .out_data (out_data)
    );

    // R1: the READ on the bus and the first tracked word agree on column
    a_r1_word0_col: assert property (@(posedge clk) disable iff (rst)
        cmd_read |-> (tag_valid && tag_col == cmd_col));

    initial begin
        a_cols: assert (NUM_COLS >= 8);
    end

endmodule

// File: tb/tb_sdram_rd_seq.sv
`timescale 1ns/1ps
module tb_sdram_rd_seq;

    localparam int BANK_W = 2;
    localparam int COL_W  = 8;
    localparam int ID_W   = 4;
    localparam int DQ_W   = 16;
    localparam int QD     = 1024;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cfg_cl3 = 1'b0, cfg_full = 1'b0;
    logic [1:0]        cfg_bl = 2'd0;
    logic              req_valid = 1'b0, req_ap = 1'b0, stop = 1'b0;
    logic [BANK_W-1:0] req_bank = '0;
    logic [COL_W-1:0]  req_col = '0;
    logic [ID_W-1:0]   req_id = '0;
    logic [DQ_W-1:0]   dq = '0;
    logic              cmd_read, cmd_ap, out_valid, out_last;
    logic [BANK_W-1:0] cmd_bank;
    logic [COL_W-1:0]  cmd_col, out_col;
    logic [ID_W-1:0]   out_id;
    logic [DQ_W-1:0]   out_data;

    sdram_rd_seq #(.BANK_W(BANK_W), .COL_W(COL_W), .ID_W(ID_W), .DQ_W(DQ_W)) dut (
        .clk(clk), .rst(rst), .cfg_cl3(cfg_cl3), .cfg_bl(cfg_bl), .cfg_full(cfg_full),
        .req_valid(req_valid), .req_bank(req_bank), .req_col(req_col), .req_ap(req_ap),
        .req_id(req_id), .stop(stop), .dq(dq), .cmd_read(cmd_read), .cmd_bank(cmd_bank),
        .cmd_col(cmd_col), .cmd_ap(cmd_ap), .out_valid(out_valid), .out_last(out_last),
        .out_id(out_id), .out_col(out_col), .out_data(out_data)
    );

    always #4 clk = ~clk;

    int errors = 0, checks = 0;
    int edge_no = 0;
    always @(posedge clk) edge_no <= edge_no + 1;
    // DQ carries the number of the edge at which it is sampled.
    always @(negedge clk) dq <= DQ_W'(edge_no + 1);

    // Expected and observed streams
    int exp_edge [QD]; int exp_col [QD]; int exp_id [QD]; bit exp_last [QD];
    int got_data [QD]; int got_col [QD]; int got_id [QD]; bit got_last [QD];
    int ne = 0, ng = 0;
    int cl = 2, blw = 1;
    bit fullm = 0;

    always @(negedge clk) begin
        if (out_valid && ng < QD) begin
            got_data[ng] = int'(out_data);
            got_col[ng]  = int'(out_col);
            got_id[ng]   = int'(out_id);
            got_last[ng] = out_last;
            ng = ng + 1;
        end
    end

    task automatic chk(input bit ok, input string what, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", what, act, expv);
        end
    endtask

    function automatic int col_of(input int start, input int i);
        int base;
        if (fullm) return (start + i) % (2 ** COL_W);
        base = start - (start % blw);
        return base + ((start % blw) + i) % blw;
    endfunction

    task automatic cut_at(input int t);
        while (ne > 0 && exp_edge[ne-1] > t + cl) ne--;
        if (ne > 0 && exp_edge[ne-1] == t + cl) exp_last[ne-1] = 1'b1;
    endtask

    // Called at a negedge; returns at the following negedge.
    task automatic send(input int bank, input int col, input bit ap, input int id);
        int t, n;
        req_valid = 1'b1; req_bank = BANK_W'(bank); req_col = COL_W'(col);
        req_ap = ap; req_id = ID_W'(id);
        t = edge_no + 1;
        cut_at(t);
        n = fullm ? 600 : blw;
        for (int i = 0; i < n; i++) begin
            exp_edge[ne] = t + 1 + cl + i;
            exp_col[ne]  = col_of(col % (2 ** COL_W), i);
            exp_id[ne]   = id;
            exp_last[ne] = (!fullm && i == n - 1);
            ne++;
        end
        @(negedge clk);
        chk(cmd_read == 1'b1, "R1 cmd_read", int'(cmd_read), 1);
        chk(int'(cmd_col) == col % (2 ** COL_W), "R1 cmd_col", int'(cmd_col), col % (2 ** COL_W));
        chk(int'(cmd_bank) == bank, "R1 cmd_bank", int'(cmd_bank), bank);
        chk(cmd_ap == ap, "R1 cmd_ap", int'(cmd_ap), int'(ap));
        req_valid = 1'b0;
    endtask

    task automatic do_stop();
        stop = 1'b1;
        cut_at(edge_no + 1);
        @(negedge clk);
        stop = 1'b0;
    endtask

    task automatic compare();
        int n;
        chk(ng == ne, "R4 R6 R7 R9 word count", ng, ne);
        n = (ng < ne) ? ng : ne;
        for (int i = 0; i < n; i++) begin
            chk(got_data[i] == (exp_edge[i] % (2 ** DQ_W)), "R2 R3 capture edge", got_data[i], exp_edge[i]);
            chk(got_col[i] == exp_col[i], "R5 R6 column", got_col[i], exp_col[i]);
            chk(got_id[i] == exp_id[i], "R12 id", got_id[i], exp_id[i]);
            chk(got_last[i] == exp_last[i], "R4 R7 R8 last", int'(got_last[i]), int'(exp_last[i]));
        end
    endtask

    typedef struct packed {
        logic       cl3;
        logic [1:0] bl;
        logic       full;
        logic [3:0] nreq;
        logic [7:0] gap;
        logic [7:0] col;
        logic       ap;
        logic [9:0] stop_after;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 2'd2, 1'b0, 4'd3, 8'd4,  8'd2,   1'b0, 10'd0},   // seamless BL4, in-block wrap
        '{1'b1, 2'd3, 1'b0, 4'd3, 8'd8,  8'd5,   1'b1, 10'd0},   // seamless BL8 at CL3
        '{1'b0, 2'd3, 1'b0, 4'd3, 8'd3,  8'd0,   1'b0, 10'd0},   // truncation every 3
        '{1'b1, 2'd0, 1'b0, 4'd5, 8'd1,  8'd7,   1'b0, 10'd0},   // BL1 every cycle
        '{1'b1, 2'd1, 1'b0, 4'd3, 8'd6,  8'd3,   1'b0, 10'd0},   // gaps between bursts
        '{1'b0, 2'd0, 1'b1, 4'd1, 8'd1,  8'd250, 1'b0, 10'd260}, // page wrap, stop
        '{1'b1, 2'd0, 1'b1, 4'd2, 8'd10, 8'd254, 1'b1, 10'd5},   // full page cut by READ
        '{1'b0, 2'd2, 1'b0, 4'd4, 8'd2,  8'd1,   1'b0, 10'd0},   // BL4 cut every 2
        '{1'b1, 2'd3, 1'b0, 4'd1, 8'd1,  8'd4,   1'b0, 10'd2}    // fixed burst stopped
    };

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        vec_t v;
        // R11: reset dominates a present request
        @(negedge clk);
        req_valid = 1'b1;
        repeat (3) @(negedge clk);
        chk(cmd_read == 1'b0, "R11 cmd_read in reset", int'(cmd_read), 0);
        chk(out_valid == 1'b0, "R11 out_valid in reset", int'(out_valid), 0);
        chk(out_last == 1'b0, "R11 out_last in reset", int'(out_last), 0);
        req_valid = 1'b0;
        rst = 1'b0;
        repeat (2) @(negedge clk);
        chk(cmd_read == 1'b0, "R1 idle cmd_read", int'(cmd_read), 0);

        for (int s = 0; s < NV; s++) begin
            v = VEC[s];
            cfg_cl3 = v.cl3; cfg_bl = v.bl; cfg_full = v.full;
            cl = v.cl3 ? 3 : 2; blw = 1 << v.bl; fullm = v.full;
            ne = 0; ng = 0;
            for (int k = 0; k < int'(v.nreq); k++) begin
                send(k % 4, int'(v.col) + 3 * k, v.ap ^ k[0], k);
                repeat (int'(v.gap) - 1) @(negedge clk);
            end
            if (v.stop_after != 0) begin
                repeat (int'(v.stop_after)) @(negedge clk);
                do_stop();
            end
            repeat (20) @(negedge clk);
            compare();
        end

        // R8: stop while idle changes nothing
        ne = 0; ng = 0;
        do_stop();
        repeat (10) @(negedge clk);
        chk(ng == 0, "R8 idle stop words", ng, 0);
        chk(cmd_read == 1'b0, "R8 idle stop cmd", int'(cmd_read), 0);

        // R10: configuration change during a burst is ignored
        cfg_cl3 = 1'b0; cfg_bl = 2'd3; cfg_full = 1'b0;
        cl = 2; blw = 8; fullm = 0;
        ne = 0; ng = 0;
        send(2, 9, 1'b0, 5);
        cfg_cl3 = 1'b1; cfg_bl = 2'd0; cfg_full = 1'b1;
        repeat (20) @(negedge clk);
        chk(ng == 8, "R10 burst length kept", ng, 8);
        compare();

        // R3 R10: the new setting applies once idle
        cl = 3; blw = 1; fullm = 0;
        cfg_full = 1'b0;
        ne = 0; ng = 0;
        send(1, 17, 1'b1, 9);
        repeat (12) @(negedge clk);
        compare();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule